// File: doc/BRIEF.md
# Nonvolatile Store Request Controller

This controller decides when the contents of an SRAM array are copied into nonvolatile cells. A copy can be requested in three ways: a digital power-loss flag, a wired-low request line shared with other devices, and a software trigger pulse. The block tracks whether the array has been written since the last copy or reload. If it has not, power-loss and line requests are dropped, so no copy is made that would change nothing. Software requests always run.

Once a copy is accepted, the block pulls the shared line low to signal that it is busy. It waits a programmable settling interval, and it extends that wait while an array access is still in flight. It then runs an erase phase followed by a program phase, each with its own programmable length in clock cycles. New writes are refused from the moment the line is seen low. Data input and output stay disabled from the erase phase until the shared line is sensed high again, because other devices may still be holding it down. The raw line level passes through a two-flop synchronizer before the block uses it.

Top module: `nvs_store_ctrl`

## Requirements
- R1: With the dirty flag clear, a high `pwr_fail_i` or a low synchronized line level does not start a copy: `line_pull_o`, `erase_o` and `prog_o` stay low.
- R2: A one-cycle `sw_store_i` pulse starts a copy even when the dirty flag is clear.
- R3: After a copy is accepted, `line_pull_o` is high with `erase_o` low for exactly DELAY_CYC cycles when `acc_busy_i` is low. While `acc_busy_i` is high, erase does not begin, and it begins on the first clock edge that sees `acc_busy_i` low after the interval.
- R4: `wr_grant_o` (equal to `wr_req_i` when allowed) is low while a copy is pending or running, while I/O is disabled, and while the synchronized line level is low. The synchronized level lags `line_sense_i` by two clock edges.
- R5: `line_pull_o` is high throughout the wait, erase and program phases, and it falls when the program phase ends.
- R6: `erase_o` is high for exactly ERASE_CYC cycles and is followed at once by `prog_o` high for exactly PROG_CYC cycles. The two are never high together, and `io_en_o` is low during both.
- R7: After the program phase, `io_en_o` stays low while `line_sense_i` is held low. It returns high within four cycles of the line being released.
- R8: A `wr_done_i` pulse sets the dirty flag. A completed copy or a `recall_done_i` pulse clears it. If `wr_done_i` and `recall_done_i` arrive in the same cycle, the flag ends set.
- R9: After reset, `line_pull_o`, `erase_o` and `prog_o` are low, `io_en_o` is high, and a write request is granted while the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_fail_i | input | 1 | Power-loss detected (level) |
| sw_store_i | input | 1 | Software copy trigger (one-cycle pulse) |
| recall_done_i | input | 1 | Pulse when a reload from nonvolatile cells finishes |
| acc_busy_i | input | 1 | An SRAM read or write is in flight |
| wr_req_i | input | 1 | Host asks to start an SRAM write |
| wr_done_i | input | 1 | Pulse when an SRAM write completes |
| line_sense_i | input | 1 | Raw sensed level of the shared wired-low line |
| line_pull_o | output | 1 | Drive the shared line low |
| wr_grant_o | output | 1 | Write request accepted |
| io_en_o | output | 1 | Data input/output enabled |
| erase_o | output | 1 | Erase phase active |
| prog_o | output | 1 | Program phase active |

## Verification
Two functions can act on the dirty flag in the same cycle: a write completion sets it, and a reload completion clears it. The bench raises `wr_done_i` and `recall_done_i` in the same cycle and then raises `pwr_fail_i`. A full erase and program sequence shows that the set won, and a missing copy shows that the clear won. The bench also holds `acc_busy_i` high past the settling interval, which makes the end of the interval and an access still in flight meet in the same cycles. It then checks that erase starts only one edge after the access ends.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_ERASE = 3'd2,
    ST_PROG  = 3'd3,
    ST_LOCK  = 3'd4
  } nvs_state_e;
endpackage

// File: rtl/nvs_sync2.sv
module nvs_sync2 #(
  parameter int unsigned WIDTH    = 1,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/nvs_dirty.sv
module nvs_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic dirty_q, dirty_d;

  // a write completing wins over a clear in the same cycle
  always_comb begin
    dirty_d = dirty_q;
    if (set_i)      dirty_d = 1'b1;
    else if (clr_i) dirty_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= 1'b0;
    else        dirty_q <= dirty_d;
  end

  assign dirty_o = dirty_q;
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_en;

  assign dec_en = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (dec_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = ~dec_en;
endmodule

// File: rtl/nvs_store_ctrl.sv
module nvs_store_ctrl #(
  parameter int unsigned DELAY_CYC = 1000,
  parameter int unsigned ERASE_CYC = 250000,
  parameter int unsigned PROG_CYC  = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic sw_store_i,
  input  logic recall_done_i,
  input  logic acc_busy_i,
  input  logic wr_req_i,
  input  logic wr_done_i,
  input  logic line_sense_i,
  output logic line_pull_o,
  output logic wr_grant_o,
  output logic io_en_o,
  output logic erase_o,
  output logic prog_o
);
  import nvs_pkg::*;

  localparam int unsigned MAX_A   = (DELAY_CYC > ERASE_CYC) ? DELAY_CYC : ERASE_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > PROG_CYC) ? MAX_A : PROG_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DLY_LD = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] ERS_LD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] PRG_LD = CNT_W'(PROG_CYC - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic       line_hi;
  logic       dirty;
  logic       tmr_zero;
  logic       tmr_ld;
  logic [CNT_W-1:0] tmr_ld_val;
  logic       store_end;
  nvs_state_e st_q, st_d;

  nvs_sync2 #(.WIDTH(1), .RST_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (line_sense_i),
    .q_o   (line_hi)
  );

  nvs_dirty u_dirty (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (wr_done_i),
    .clr_i   (store_end | recall_done_i),
    .dirty_o (dirty)
  );

  nvs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_ld),
    .load_val_i (tmr_ld_val),
    .zero_o     (tmr_zero)
  );

  // next-state logic
  always_comb begin
    st_d       = st_q;
    tmr_ld     = 1'b0;
    tmr_ld_val = '0;
    store_end  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sw_store_i || (dirty && (pwr_fail_i || !line_hi))) begin
          st_d       = ST_HOLD;
          tmr_ld     = 1'b1;
          tmr_ld_val = DLY_LD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero && !acc_busy_i) begin
          st_d       = ST_ERASE;
          tmr_ld     = 1'b1;
          tmr_ld_val = ERS_LD;
        end
      end
      ST_ERASE: begin
        if (tmr_zero) begin
          st_d       = ST_PROG;
          tmr_ld     = 1'b1;
          tmr_ld_val = PRG_LD;
        end
      end
      ST_PROG: begin
        if (tmr_zero) begin
          st_d      = ST_LOCK;
          store_end = 1'b1;
        end
      end
      ST_LOCK: begin
        if (line_hi) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  assign erase_o     = (st_q == ST_ERASE);
  assign prog_o      = (st_q == ST_PROG);
  assign line_pull_o = (st_q == ST_HOLD) || erase_o || prog_o;
  assign io_en_o     = !(erase_o || prog_o || (st_q == ST_LOCK));
  assign wr_grant_o  = wr_req_i && (st_q == ST_IDLE) && line_hi;
endmodule

// File: rtl/nvs_store_ctrl_chk.sv
module nvs_store_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_busy_i,
  input logic line_pull_o,
  input logic wr_grant_o,
  input logic io_en_o,
  input logic erase_o,
  input logic prog_o
);
  p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_o && prog_o));

  p_erase_then_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_o) |-> prog_o);

  p_io_off_in_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_o || prog_o) |-> !io_en_o);

  p_pull_in_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_o || prog_o) |-> line_pull_o);

  p_no_grant_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_o |-> !wr_grant_o);

  p_no_grant_io_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en_o |-> !wr_grant_o);

  p_erase_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_o) |-> !$past(acc_busy_i));
endmodule

bind nvs_store_ctrl nvs_store_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_busy_i  (acc_busy_i),
  .line_pull_o (line_pull_o),
  .wr_grant_o  (wr_grant_o),
  .io_en_o     (io_en_o),
  .erase_o     (erase_o),
  .prog_o      (prog_o)
);

// File: tb/nvs_store_ctrl_tb.sv
module nvs_store_ctrl_tb;
  localparam int DLY = 4;
  localparam int ERS = 6;
  localparam int PRG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0, sw_store = 1'b0, recall_done = 1'b0, acc_busy = 1'b0;
  logic wr_req = 1'b0, wr_done = 1'b0, ext_pull = 1'b0;
  logic line_pull, wr_grant, io_en, erase, prog, line_sense;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign line_sense = !(line_pull || ext_pull);

  nvs_store_ctrl #(.DELAY_CYC(DLY), .ERASE_CYC(ERS), .PROG_CYC(PRG)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail), .sw_store_i(sw_store),
    .recall_done_i(recall_done), .acc_busy_i(acc_busy), .wr_req_i(wr_req),
    .wr_done_i(wr_done), .line_sense_i(line_sense), .line_pull_o(line_pull),
    .wr_grant_o(wr_grant), .io_en_o(io_en), .erase_o(erase), .prog_o(prog)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // samples each cycle after the request edge; clears one-shot inputs
  task automatic measure(output int h, output int e, output int p);
    h = 0; e = 0; p = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      sw_store = 1'b0;
      pwr_fail = 1'b0;
      if (prog) p++;
      else if (erase) e++;
      else if (line_pull) h++;
      if (p > 0 && !prog) break;
    end
  endtask

  task automatic wr_pulse();
    @(negedge clk); wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
  endtask

  // watches for any copy activity over n cycles
  task automatic watch_idle(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pwr_fail = 1'b0;
      if (line_pull || erase || prog) seen++;
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 5; i++) @(negedge clk);
  endtask

  initial begin
    int h, e, p, seen, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr_req = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!line_pull, "R9 pull", line_pull, 0);
    chk(!erase && !prog, "R9 phases", erase | prog, 0);
    chk(io_en, "R9 io_en", io_en, 1);
    chk(wr_grant, "R9 grant", wr_grant, 1);

    // R2 software copy while clean; also R3/R6 lengths
    sw_store = 1'b1;
    measure(h, e, p);
    chk(h == DLY, "R3 hold length", h, DLY);
    chk(e == ERS, "R6 erase length", e, ERS);
    chk(p == PRG, "R2 R6 prog length", p, PRG);
    chk(!line_pull, "R5 pull released", line_pull, 0);
    settle();
    chk(io_en, "R7 io back", io_en, 1);

    // R1 power loss while clean (also R8 store cleared dirty)
    pwr_fail = 1'b1;
    watch_idle(12, seen);
    chk(seen == 0, "R1 pwr clean skip", seen, 0);

    // R1 dirty power loss runs
    wr_pulse();
    @(negedge clk); pwr_fail = 1'b1;
    measure(h, e, p);
    chk(e == ERS && p == PRG, "R1 pwr dirty runs", e + p, ERS + PRG);
    settle();

    // R1 hardware line low while clean: no copy; R4 grants blocked
    ext_pull = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_grant, "R4 grant blocked line low", wr_grant, 0);
    watch_idle(10, seen);
    chk(seen == 0, "R1 line clean skip", seen, 0);
    ext_pull = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_grant, "R4 grant restored", wr_grant, 1);

    // dirty + line low: copy runs, then lock while line held (R7)
    wr_pulse();
    @(negedge clk); ext_pull = 1'b1;
    measure(h, e, p);
    chk(e == ERS && p == PRG, "R1 line dirty runs", e + p, ERS + PRG);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (io_en || wr_grant) cnt++;
    end
    chk(cnt == 0, "R7 locked while line low", cnt, 0);
    ext_pull = 1'b0;
    repeat (4) @(negedge clk);
    chk(io_en, "R7 release unlocks", io_en, 1);

    // R3 access in flight extends the wait
    acc_busy = 1'b1;
    sw_store = 1'b1;
    cnt = 0;
    for (int i = 0; i < DLY + 6; i++) begin
      @(negedge clk);
      sw_store = 1'b0;
      if (erase) cnt++;
      if (!line_pull) cnt++;
    end
    chk(cnt == 0, "R3 wait held by busy", cnt, 0);
    acc_busy = 1'b0;
    @(negedge clk);
    chk(erase, "R3 erase after busy drop", erase, 1);
    measure(h, e, p);
    chk(e == ERS - 1 && p == PRG, "R6 lengths after busy", e + p, ERS - 1 + PRG);
    settle();

    // R8 recall clears dirty
    wr_pulse();
    @(negedge clk); recall_done = 1'b1;
    @(negedge clk); recall_done = 1'b0; pwr_fail = 1'b1;
    watch_idle(12, seen);
    chk(seen == 0, "R8 recall clears", seen, 0);

    // R8 write and recall in the same cycle: dirty stays set
    @(negedge clk); wr_done = 1'b1; recall_done = 1'b1;
    @(negedge clk); wr_done = 1'b0; recall_done = 1'b0; pwr_fail = 1'b1;
    measure(h, e, p);
    chk(e == ERS && p == PRG, "R8 write wins tie", e + p, ERS + PRG);
    settle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule